// File: doc/BRIEF.md
# Parking Occupancy Gate Controller

This block tracks how many cars are inside a parking area and decides when the barrier opens. It has two sensor inputs: one for the entrance lane and one for the exit lane. Each is a level signal that is already synchronous to the clock. The block turns the rising edge of each sensor into a single event. It then adjusts an occupancy counter that stops at zero and at a capacity set by a parameter. From the counter it drives a full/available status flag and a one-cycle gate-raise pulse.

Both sensors are plain control pins, and the status pins are plain as well. No data stream enters or leaves the block, so there is no valid/ready handshake and no back-pressure to define. A sensor rise is taken on the clock edge where it is first seen. There is no way to stall it.

The occupancy is given as a binary value for an external display. A car arriving at a full lot is refused: the count does not move and the gate stays down. A departure always opens the gate. If an arrival and a departure are seen on the same clock edge, they cancel in the count.

Top module: `park_occupancy_ctrl`

## Requirements
- R1: A rising edge on `entry_sense` while `lot_full` is low and `exit_sense` shows no rising edge raises `occupancy` by exactly one. The new value is visible after the clock edge that first samples the sensor high.
- R2: A rising edge on `exit_sense` while `occupancy` is non-zero and `entry_sense` shows no rising edge lowers `occupancy` by exactly one, with the same timing as R1.
- R3: Only a low-to-high change of a sensor makes an event. Holding a sensor high for many cycles counts once. A sensor that is already high when reset is released makes no event until it has gone low and high again.
- R4: `lot_full` is high exactly when `occupancy` equals `CAPACITY`, and low otherwise.
- R5: An entry event while `lot_full` is high is ignored: `occupancy` stays at `CAPACITY` and `gate_raise` stays low.
- R6: An exit event while `occupancy` is zero leaves `occupancy` at zero. It still raises the gate, because a departing car must be let out.
- R7: When entry and exit events fall on the same clock edge, `occupancy` is unchanged and `gate_raise` pulses. This holds at any occupancy, including empty and full.
- R8: `gate_raise` is a registered output. It is high for exactly the one cycle after the edge that sampled an accepted entry or any exit event, and low otherwise.
- R9: A synchronous active-high `rst` sets `occupancy` to zero and drives `lot_full` and `gate_raise` low on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| entry_sense | input | 1 | Entrance lane sensor level |
| exit_sense | input | 1 | Exit lane sensor level |
| occupancy | output | $clog2(CAPACITY+1) | Cars currently inside, binary |
| lot_full | output | 1 | High when no space is free; low means spaces are available |
| gate_raise | output | 1 | One-cycle command to raise the barrier |

## Verification
An entry event and an exit event can land on the same clock edge. That is the collision that matters most: the count must hold still while the gate still pulses. The bench drives both sensors high in the same cycle at every occupancy level from empty to full, including both saturation ends. After each such edge it compares the count and the gate pulse against an arithmetic model. It also runs the single-event cases at both limits, so that a refused entry at full and a clamped exit at empty are each judged apart from the collision case.

// File: rtl/park_pkg.sv
package park_pkg;

  // Classification of the sensor events sampled on one clock edge.
  typedef enum logic [1:0] {
    EV_NONE = 2'b00,
    EV_IN   = 2'b01,
    EV_OUT  = 2'b10,
    EV_SWAP = 2'b11
  } park_ev_e;

  localparam int SENSOR_N = 2;
  localparam int SNS_IN   = 0;
  localparam int SNS_OUT  = 1;

endpackage

// File: rtl/park_rise_det.sv
module park_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  // prev follows the input even during reset, so a level held high
  // across reset release is not seen as a new arrival.
  always_ff @(posedge clk) begin
    prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q & ~rst;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o) else $error("rise pulse longer than one cycle"); // R3

endmodule

// File: rtl/park_count.sv
module park_count
  import park_pkg::*;
#(
  parameter int CAPACITY = 12,
  localparam int CNT_W = $clog2(CAPACITY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_in,
  input  logic             ev_out,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAPACITY);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full_q;
  park_ev_e         kind;

  assign kind = park_ev_e'({ev_out, ev_in});

  always_comb begin
    cnt_d = cnt_q;
    unique case (kind)
      EV_IN:   if (!full_q)          cnt_d = cnt_q + 1'b1;
      EV_OUT:  if (cnt_q != '0)      cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= (cnt_d == CAP_V);
    end
  end

  assign count_o = cnt_q;
  assign full_o  = full_q;

  AST_ENTRY_STEP: assert property (@(posedge clk) disable iff (rst)
    (ev_in && !ev_out && !full_q) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)))
    else $error("entry step wrong"); // R1
  AST_EXIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (ev_out && !ev_in && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)))
    else $error("exit step wrong"); // R2
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ev_in && !ev_out && full_q) |=> $stable(cnt_q)) else $error("full overrun"); // R5
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ev_out && !ev_in && cnt_q == '0) |=> (cnt_q == '0)) else $error("empty underrun"); // R6
  AST_SWAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ev_in && ev_out) |=> $stable(cnt_q)) else $error("swap moved count"); // R7

endmodule

// File: rtl/park_gate.sv
module park_gate (
  input  logic clk,
  input  logic rst,
  input  logic ev_in,
  input  logic ev_out,
  input  logic full_i,
  output logic raise_o
);
  logic raise_q;

  always_ff @(posedge clk) begin
    if (rst) raise_q <= 1'b0;
    else     raise_q <= ev_out | (ev_in & ~full_i);
  end

  assign raise_o = raise_q;

  AST_FULL_NO_RAISE: assert property (@(posedge clk) disable iff (rst)
    (ev_in && !ev_out && full_i) |=> !raise_q) else $error("gate opened while full"); // R5
  AST_EXIT_RAISE: assert property (@(posedge clk) disable iff (rst)
    ev_out |=> raise_q) else $error("exit without gate"); // R8

endmodule

// File: rtl/park_occupancy_ctrl.sv
module park_occupancy_ctrl
  import park_pkg::*;
#(
  parameter int CAPACITY = 12,
  localparam int CNT_W = $clog2(CAPACITY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             entry_sense,
  input  logic             exit_sense,
  output logic [CNT_W-1:0] occupancy,
  output logic             lot_full,
  output logic             gate_raise
);
  logic [SENSOR_N-1:0] sense_lv;
  logic [SENSOR_N-1:0] sense_ev;

  assign sense_lv[SNS_IN]  = entry_sense;
  assign sense_lv[SNS_OUT] = exit_sense;

  for (genvar g = 0; g < SENSOR_N; g++) begin : g_rise
    park_rise_det u_rise (
      .clk     (clk),
      .rst     (rst),
      .level_i (sense_lv[g]),
      .rise_o  (sense_ev[g])
    );
  end

  park_count #(.CAPACITY(CAPACITY)) u_count (
    .clk     (clk),
    .rst     (rst),
    .ev_in   (sense_ev[SNS_IN]),
    .ev_out  (sense_ev[SNS_OUT]),
    .count_o (occupancy),
    .full_o  (lot_full)
  );

  park_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .ev_in   (sense_ev[SNS_IN]),
    .ev_out  (sense_ev[SNS_OUT]),
    .full_i  (lot_full),
    .raise_o (gate_raise)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    occupancy <= CNT_W'(CAPACITY)) else $error("count above capacity"); // R4
  AST_FULL_MATCH: assert property (@(posedge clk) disable iff (rst)
    lot_full == (occupancy == CNT_W'(CAPACITY))) else $error("full flag mismatch"); // R4
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (occupancy == '0 && !lot_full && !gate_raise)) else $error("reset incomplete"); // R9

endmodule

// File: tb/park_occupancy_ctrl_tb.sv
`timescale 1ns/1ps
module park_occupancy_ctrl_tb;
  localparam int CAP = 5;
  localparam int W   = $clog2(CAP + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic entry_sense = 1'b0;
  logic exit_sense  = 1'b0;
  logic [W-1:0] occupancy;
  logic lot_full, gate_raise;

  int total = 0;
  int bad   = 0;
  int exp_cnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  park_occupancy_ctrl #(.CAPACITY(CAP)) u_dut (
    .clk(clk), .rst(rst), .entry_sense(entry_sense), .exit_sense(exit_sense),
    .occupancy(occupancy), .lot_full(lot_full), .gate_raise(gate_raise)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One event: drive at negedge, sampled at next posedge, check at next negedge.
  task automatic event_step(bit i, bit o, string tag);
    int exp_gate;
    entry_sense = i;
    exit_sense  = o;
    @(negedge clk);
    exp_gate = 0;
    if (i && o) exp_gate = 1;
    else if (i) begin
      if (exp_cnt < CAP) begin exp_cnt++; exp_gate = 1; end
    end else if (o) begin
      if (exp_cnt > 0) exp_cnt--;
      exp_gate = 1;
    end
    check({tag, " count"}, int'(occupancy), exp_cnt);
    check({tag, " R4 full"}, int'(lot_full), (exp_cnt == CAP) ? 1 : 0);
    check({tag, " R8 gate"}, int'(gate_raise), exp_gate);
    entry_sense = 1'b0;
    exit_sense  = 1'b0;
    @(negedge clk);
    check({tag, " R8 gate drop"}, int'(gate_raise), 0);
    check({tag, " count hold"}, int'(occupancy), exp_cnt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset count", int'(occupancy), 0);
    check("R9 reset full", int'(lot_full), 0);
    check("R9 reset gate", int'(gate_raise), 0);

    // Fill past capacity: R1 then R5 refusals.
    for (int k = 0; k < CAP + 2; k++) event_step(1'b1, 1'b0, (k < CAP) ? "R1 entry" : "R5 entry at full");
    // Simultaneous events at full.
    event_step(1'b1, 1'b1, "R7 swap at full");
    // Drain below empty: R2 then R6.
    for (int k = 0; k < CAP + 2; k++) event_step(1'b0, 1'b1, (k < CAP) ? "R2 exit" : "R6 exit at empty");
    // Swap at every level from empty to full.
    for (int lvl = 0; lvl <= CAP; lvl++) begin
      event_step(1'b1, 1'b1, "R7 swap");
      if (lvl < CAP) event_step(1'b1, 1'b0, "R1 climb");
    end

    // R3: hold entry high for several cycles -> counts once.
    while (exp_cnt > 1) event_step(1'b0, 1'b1, "R2 down");
    entry_sense = 1'b1;
    repeat (6) @(negedge clk);
    exp_cnt++;
    check("R3 held level counts once", int'(occupancy), exp_cnt);
    check("R3 held level gate low", int'(gate_raise), 0);
    entry_sense = 1'b0;
    @(negedge clk);
    check("R3 release no event", int'(occupancy), exp_cnt);

    // R9: reset mid-count, with entry held high across release (R3).
    entry_sense = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset clears count", int'(occupancy), 0);
    check("R9 reset clears gate", int'(gate_raise), 0);
    rst = 1'b0;
    exp_cnt = 0;
    repeat (3) @(negedge clk);
    check("R3 level across reset ignored", int'(occupancy), 0);
    entry_sense = 1'b0;
    @(negedge clk);
    event_step(1'b1, 1'b0, "R1 after reset");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule